// File: doc/BRIEF.md
# Misaligned Load Splitter

This block sits between a load request port and a 32-bit little-endian memory bus that selects bytes with four lane enables instead of the two low address bits. A request carries a byte address, an access size and a strobe. The block drives one or two bus cycles, each with a word address and a lane mask. It collects the returned bytes into a right-justified, zero-extended result and raises a one-cycle done pulse.

An access that crosses a word boundary is split into two partial-lane cycles. The lower-addressed word is always read first. Bytes are packed into the result in increasing address order. When the strict input is high, a crossing access starts no bus cycle and raises a one-cycle fault pulse instead. Accesses that stay inside one word behave the same whatever the strict input is.

Top module: `lsu_split_load`

## Requirements
- R1: After reset, bus valid, all lane enables, done and fault are low. Whenever bus valid is low, the lane enables are zero.
- R2: The first bus cycle carries address bits 31:2 as the word address. The second cycle of a split carries that word address plus one, and it wraps to zero from the top word.
- R3: A word access (size code 2'b10) at offset 0 takes one bus cycle with lane mask 4'b1111. The result is the full 32-bit bus data, unchanged.
- R4: A byte access (size code 2'b00) takes one bus cycle. It enables only the lane equal to address bits 1:0, where lane i is data bits 8i+7:8i. The result holds that byte in bits 7:0, with bits 31:8 zero.
- R5: A halfword access (size code 2'b01) at offset 0, 1 or 2 takes one bus cycle. It enables the two lanes starting at the offset and puts those bytes in result bits 15:0, lower address in bits 7:0, with bits 31:16 zero.
- R6: With strict low, a word access at offset 1, 2 or 3 takes two bus cycles. The first enables the lanes from the offset up to lane 3. The second enables the lanes below the offset in the next word. Result byte k is the byte at address+k.
- R7: With strict low, a halfword at offset 3 takes two bus cycles. The first uses lane 3 of the containing word, which goes to result bits 7:0. The second uses lane 0 of the next word, which goes to bits 15:8.
- R8: With strict high, a word access at a non-zero offset or a halfword at offset 3 starts no bus cycle. Fault is high for exactly one cycle, the cycle after the request, and done stays low.
- R9: Each bus cycle holds valid, word address and lanes until ready is high. Data is taken only in a cycle with ready high. Done is high for exactly the one cycle after the final handshake, and the result is valid while done is high.
- R10: A request strobe that arrives while an access is in progress is ignored. The result and the bus sequence of the current access are unchanged, and no further bus cycle follows its done.
- R11: With strict high, accesses that do not cross a word boundary (for example a halfword at offset 1 or 2) complete exactly as with strict low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strict_i | input | 1 | High: crossing accesses fault instead of splitting |
| req_valid_i | input | 1 | Request strobe, sampled only while idle |
| req_addr_i | input | 32 | Byte address of the load |
| req_size_i | input | 2 | 00 byte, 01 halfword, 10 word |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle misalignment fault pulse |
| result_o | output | 32 | Right-justified, zero-extended load data |
| bus_valid_o | output | 1 | Bus cycle request |
| bus_ready_i | input | 1 | Bus accepts the cycle and returns data |
| bus_waddr_o | output | 30 | Word address |
| bus_lanes_o | output | 4 | Byte-lane enables |
| bus_rdata_i | input | 32 | Read data, lane i on bits 8i+7:8i |

## Verification
A wrong sequencer state shows at the bus ports in the next cycle: a missing, extra or repeated bus cycle, a word address that is not the expected word or its successor, or a lane mask that differs from the offset and size. A wrong steering decision shows only at done, as a misplaced or stale byte in the result. A wrong fault decision appears one cycle after the request, either as a fault pulse or as a bus cycle where the other was due. The bench offers a different garbage word on cycles without ready, so capturing data on the wrong cycle also shows in the result.

// File: rtl/lsu_split_pkg.sv
package lsu_split_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_LO   = 2'b01,
    ST_HI   = 2'b10
  } seq_state_e;

endpackage

// File: rtl/split_plan.sv
module split_plan
  import lsu_split_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [$clog2(LANES)-1:0] off_i,
  input  logic [1:0]               size_i,
  input  logic                     strict_i,
  output logic [LANES-1:0]         lanes_lo_o,
  output logic [LANES-1:0]         lanes_hi_o,
  output logic [$clog2(LANES):0]   nbytes_o,
  output logic                     split_o,
  output logic                     fault_o
);

  localparam int OFF_W = $clog2(LANES);

  logic [OFF_W:0] end_pos;

  always_comb begin
    case (size_i)
      SZ_BYTE: nbytes_o = (OFF_W+1)'(1);
      SZ_HALF: nbytes_o = (OFF_W+1)'(2);
      default: nbytes_o = (OFF_W+1)'(LANES);
    endcase
  end

  assign end_pos  = {1'b0, off_i} + nbytes_o;
  assign split_o  = (end_pos > (OFF_W+1)'(LANES));
  assign fault_o  = strict_i & split_o;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam logic [OFF_W:0] JV  = (OFF_W+1)'(j);
    localparam logic [OFF_W:0] JHI = (OFF_W+1)'(j + LANES);
    logic in_lo;
    logic in_hi;
    always_comb begin
      in_lo = (JV >= {1'b0, off_i}) && ((JV - {1'b0, off_i}) < nbytes_o);
      in_hi = ((JHI - {1'b0, off_i}) < nbytes_o);
    end
    assign lanes_lo_o[j] = in_lo;
    assign lanes_hi_o[j] = in_hi;
  end

endmodule

// File: rtl/lane_gather.sv
module lane_gather #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_i,
  input  logic                          cap_i,
  input  logic                          phase_i,
  input  logic [$clog2(LANES)-1:0]      off_i,
  input  logic [$clog2(LANES):0]        nbytes_i,
  input  logic [LANES*BYTE_W-1:0]       rdata_i,
  output logic [LANES*BYTE_W-1:0]       result_o
);

  localparam int OFF_W = $clog2(LANES);

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    localparam logic [OFF_W:0] KV = (OFF_W+1)'(k);
    logic [OFF_W:0]    src;
    logic              take;
    logic [BYTE_W-1:0] byte_d;
    logic [BYTE_W-1:0] byte_q;

    always_comb begin
      src    = {1'b0, off_i} + KV;
      take   = cap_i && (src[OFF_W] == phase_i) && (KV < nbytes_i);
      byte_d = byte_q;
      if (clr_i) begin
        byte_d = '0;
      end else if (take) begin
        byte_d = rdata_i[src[OFF_W-1:0]*BYTE_W +: BYTE_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (clr_i || take) begin
        byte_q <= byte_d;
      end
    end

    assign result_o[k*BYTE_W +: BYTE_W] = byte_q;
  end

endmodule

// File: rtl/split_seq.sv
module split_seq
  import lsu_split_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid_i,
  input  logic plan_split_i,
  input  logic plan_fault_i,
  input  logic bus_ready_i,
  output logic accept_o,
  output logic bus_valid_o,
  output logic phase_o,
  output logic cap_o,
  output logic done_o,
  output logic fault_o
);

  seq_state_e state_q, state_d;
  logic       done_d, fault_d;

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    done_d   = 1'b0;
    fault_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          if (plan_fault_i) begin
            fault_d = 1'b1;
          end else begin
            accept_o = 1'b1;
            state_d  = ST_LO;
          end
        end
      end
      ST_LO: begin
        if (bus_ready_i) begin
          if (plan_split_i) begin
            state_d = ST_HI;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      ST_HI: begin
        if (bus_ready_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
      fault_o <= fault_d;
    end
  end

  assign bus_valid_o = (state_q != ST_IDLE);
  assign phase_o     = (state_q == ST_HI);
  assign cap_o       = bus_valid_o & bus_ready_i;

  AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> !fault_o); // R8
  AST_FAULT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !bus_valid_o && !done_o); // R8
  AST_STALL_KEEPS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && !bus_ready_i) |=> bus_valid_o && $stable(phase_o)); // R9
  AST_DONE_AFTER_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(bus_valid_o && bus_ready_i)); // R9

endmodule

// File: rtl/lsu_split_load.sv
module lsu_split_load
  import lsu_split_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       strict_i,
  input  logic                       req_valid_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic [1:0]                 req_size_i,
  output logic                       done_o,
  output logic                       fault_o,
  output logic [LANES*BYTE_W-1:0]    result_o,
  output logic                       bus_valid_o,
  input  logic                       bus_ready_i,
  output logic [ADDR_W-$clog2(LANES)-1:0] bus_waddr_o,
  output logic [LANES-1:0]           bus_lanes_o,
  input  logic [LANES*BYTE_W-1:0]    bus_rdata_i
);

  localparam int OFF_W   = $clog2(LANES);
  localparam int WADDR_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [1:0]        size_q, size_d;
  logic [OFF_W-1:0]  plan_off;
  logic [1:0]        plan_size;
  logic [LANES-1:0]  lanes_lo, lanes_hi;
  logic [OFF_W:0]    nbytes;
  logic              plan_split, plan_fault;
  logic              accept, phase, cap;

  always_comb begin
    plan_off  = bus_valid_o ? addr_q[OFF_W-1:0] : req_addr_i[OFF_W-1:0];
    plan_size = bus_valid_o ? size_q : req_size_i;
    addr_d    = accept ? req_addr_i : addr_q;
    size_d    = accept ? req_size_i : size_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      size_q <= SZ_BYTE;
    end else if (accept) begin
      addr_q <= addr_d;
      size_q <= size_d;
    end
  end

  split_plan #(.LANES(LANES)) u_plan (
    .off_i      (plan_off),
    .size_i     (plan_size),
    .strict_i   (strict_i),
    .lanes_lo_o (lanes_lo),
    .lanes_hi_o (lanes_hi),
    .nbytes_o   (nbytes),
    .split_o    (plan_split),
    .fault_o    (plan_fault)
  );

  split_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .plan_split_i (plan_split),
    .plan_fault_i (plan_fault),
    .bus_ready_i  (bus_ready_i),
    .accept_o     (accept),
    .bus_valid_o  (bus_valid_o),
    .phase_o      (phase),
    .cap_o        (cap),
    .done_o       (done_o),
    .fault_o      (fault_o)
  );

  lane_gather #(.LANES(LANES), .BYTE_W(BYTE_W)) u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (accept),
    .cap_i    (cap),
    .phase_i  (phase),
    .off_i    (addr_q[OFF_W-1:0]),
    .nbytes_i (nbytes),
    .rdata_i  (bus_rdata_i),
    .result_o (result_o)
  );

  assign bus_waddr_o = addr_q[ADDR_W-1:OFF_W] + WADDR_W'(phase);
  assign bus_lanes_o = !bus_valid_o ? '0 : (phase ? lanes_hi : lanes_lo);

  AST_IDLE_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid_o |-> (bus_lanes_o == '0)); // R1
  AST_BUSY_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o |-> (bus_lanes_o != '0)); // R2
  AST_STALL_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && !bus_ready_i) |=> $stable(bus_waddr_o) && $stable(bus_lanes_o)); // R9
  AST_HI_NEXT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && $past(bus_valid_o) && $past(bus_ready_i) && (bus_lanes_o != $past(bus_lanes_o) || bus_waddr_o != $past(bus_waddr_o)))
      |-> (bus_waddr_o == $past(bus_waddr_o) + WADDR_W'(1))); // R2

endmodule

// File: tb/tb_lsu_split_load.sv
module tb_lsu_split_load;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strict_i;
  logic        req_valid_i;
  logic [31:0] req_addr_i;
  logic [1:0]  req_size_i;
  logic        done_o, fault_o;
  logic [31:0] result_o;
  logic        bus_valid_o;
  logic        bus_ready_i;
  logic [29:0] bus_waddr_o;
  logic [3:0]  bus_lanes_o;
  logic [31:0] bus_rdata_i;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lsu_split_load dut (
    .clk(clk), .rst_n(rst_n), .strict_i(strict_i), .req_valid_i(req_valid_i),
    .req_addr_i(req_addr_i), .req_size_i(req_size_i), .done_o(done_o),
    .fault_o(fault_o), .result_o(result_o), .bus_valid_o(bus_valid_o),
    .bus_ready_i(bus_ready_i), .bus_waddr_o(bus_waddr_o),
    .bus_lanes_o(bus_lanes_o), .bus_rdata_i(bus_rdata_i)
  );

  function automatic logic [7:0] mb(input logic [31:0] a);
    mb = (a[7:0] * 8'd13) ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] mword(input logic [29:0] w);
    mword = {mb({w, 2'd3}), mb({w, 2'd2}), mb({w, 2'd1}), mb({w, 2'd0})};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic run_req(input logic [31:0] a, input logic [1:0] sz, input logic st,
                         input int waitn, input bit inject);
    int n, o, ncyc_exp, ncyc, wc;
    bit split, efault, prev_hs, seen_done;
    logic [3:0]  m1, m2, elanes;
    logic [31:0] eres;
    logic [29:0] ew;
    string tag;
    n = 1 << sz;
    o = int'(a[1:0]);
    split = (o + n) > 4;
    efault = st && split;
    m1 = 4'(((1 << n) - 1) << o);
    m2 = 4'((((1 << n) - 1) << o) >> 4);
    ncyc_exp = efault ? 0 : (split ? 2 : 1);
    eres = '0;
    for (int k = 0; k < n; k++) eres[8*k +: 8] = mb(a + 32'(k));
    if (efault) tag = "R8";
    else if (sz == 2'b00) tag = "R4";
    else if (sz == 2'b01) tag = (o == 3) ? "R7" : (st ? "R11" : "R5");
    else tag = (o == 0) ? "R3" : "R6";

    @(negedge clk);
    strict_i = st; req_addr_i = a; req_size_i = sz; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    ncyc = 0; wc = 0; prev_hs = 0; seen_done = 0;
    for (int i = 0; i < 60; i++) begin
      if (inject && i == 0) begin
        req_valid_i = 1'b1; req_addr_i = a ^ 32'h40; req_size_i = 2'b10;
      end
      if (inject && i == 1) req_valid_i = 1'b0;
      chk(done_o == (!efault && prev_hs && ncyc == ncyc_exp), "R9", 32'(done_o),
          32'(!efault && prev_hs && ncyc == ncyc_exp));
      if (i == 0) chk(fault_o == efault, tag, 32'(fault_o), 32'(efault));
      else chk(fault_o == 1'b0, "R8", 32'(fault_o), 32'd0);
      if (done_o) begin
        seen_done = 1;
        chk(result_o == eres, inject ? "R10" : tag, result_o, eres);
        bus_ready_i = 1'b0;
        break;
      end
      if (efault && i >= 3) break;
      if (bus_valid_o) begin
        chk(ncyc < ncyc_exp, efault ? "R8" : tag, 32'(ncyc), 32'(ncyc_exp));
        ew = (ncyc == 0) ? a[31:2] : a[31:2] + 30'd1;
        elanes = (ncyc == 0) ? m1 : m2;
        chk(bus_waddr_o == ew, "R2", 32'(bus_waddr_o), 32'(ew));
        chk(bus_lanes_o == elanes, tag, 32'(bus_lanes_o), 32'(elanes));
        if (wc >= waitn) begin
          bus_ready_i = 1'b1; bus_rdata_i = mword(bus_waddr_o);
          prev_hs = 1; ncyc++; wc = 0;
        end else begin
          bus_ready_i = 1'b0; bus_rdata_i = 32'hDEAD_BEEF ^ 32'(i);
          prev_hs = 0; wc++;
        end
      end else begin
        bus_ready_i = 1'b0;
        prev_hs = 0;
      end
      @(negedge clk);
    end
    if (!efault) chk(seen_done, "R9", 32'(seen_done), 32'd1);
    @(negedge clk);
    chk(!bus_valid_o && !done_o && !fault_o, inject ? "R10" : "R9",
        {29'd0, bus_valid_o, done_o, fault_o}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    logic [31:0] bases [3];
    bases[0] = 32'h0000_1000;
    bases[1] = 32'hFFFF_FFFC;
    bases[2] = 32'h2468_ACE0;
    rst_n = 1'b0; strict_i = 1'b0; req_valid_i = 1'b0; req_addr_i = '0;
    req_size_i = 2'b00; bus_ready_i = 1'b0; bus_rdata_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!bus_valid_o && bus_lanes_o == 4'd0 && !done_o && !fault_o, "R1",
        {27'd0, bus_lanes_o, bus_valid_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_valid_o && bus_lanes_o == 4'd0, "R1", {27'd0, bus_lanes_o, bus_valid_o}, 32'd0);
    for (int st = 0; st < 2; st++)
      for (int sz = 0; sz < 3; sz++)
        for (int b = 0; b < 3; b++)
          for (int o = 0; o < 4; o++)
            for (int w = 0; w < 3; w += 2)
              run_req(bases[b] + 32'(o), 2'(sz), 1'(st), w, 1'b0);
    // R10: strobe during a split access and during a single access
    run_req(32'h0000_2003, 2'b10, 1'b0, 1, 1'b1);
    run_req(32'h0000_2001, 2'b01, 1'b0, 2, 1'b1);
    run_req(32'h0000_2002, 2'b10, 1'b0, 0, 1'b1);
    summary();
  end

endmodule